// File: doc/BRIEF.md
# Eight-bit flag-setting ALU with condition-code register

This block computes the data result and the condition-code update for every single-byte operation of a small accumulator machine. Given an operation code, a register operand, a memory operand and the current condition-code byte, it returns an 8-bit result, a flag saying whether that result is written back, and a new condition-code byte. Each operation touches only its own set of arithmetic flags; the interrupt-mask and state bits pass through untouched.

The data path is purely combinational. The new condition-code byte is captured into a register on the clock edge that ends a valid, recognised operation, and the register holds its value otherwise. Single-operand operations (negate, complement, shifts, rotates, increment, decrement, test, clear, load) act on the memory operand; two-operand operations combine the register operand (left side) with the memory operand (right side). Store and sign-extend take the register operand.

Top module: `cc_alu8`

## Requirements
- R1: Condition-code bit positions are 7 = entire-state, 6 = fast-mask, 5 = half-carry H, 4 = mask, 3 = N, 2 = Z, 1 = V, 0 = C. `cc_q` resets to 8'h50, loads the updated byte on a clock edge where `op_valid` is high and the op code is recognised, and otherwise holds; bits 7, 6 and 4 of the loaded byte always equal those of `cc_in`.
- R2: ADD (op 15) and ADC (op 16) return reg + mem (+ C for ADC), set H to the carry out of bit 3, C to the carry out of bit 7, V to signed overflow, N and Z from the result; result is written.
- R3: SUB (op 17), SBC (op 18) and CMP (op 19) return reg − mem (− C for SBC); C is set when mem plus borrow-in exceeds reg unsigned, V when the operand signs differ and the result sign differs from reg; N, Z from result; CMP does not write.
- R4: NEG (op 0) returns 0 − mem; C is set for any non-zero operand, V only for 8'h80; N and Z from the result.
- R5: INC (op 7) and DEC (op 8) return mem ± 1, set V only when crossing 8'h7F/8'h80 in the signed direction, update N and Z, and keep C.
- R6: COM (op 1) returns the bitwise inverse of mem, clears V, sets C, updates N and Z.
- R7: LSR (op 2) and ASR (op 3) shift mem right by one with old bit 0 into C; LSR fills bit 7 with 0, ASR keeps bit 7; N, Z updated, V kept.
- R8: ASL (op 4) shifts left filling 0, ROL (op 5) shifts left filling with C, ROR (op 6) shifts right filling bit 7 with C. ASL and ROL set C to old bit 7 and V to old bit 7 XOR old bit 6; ROR sets C to old bit 0 and keeps V.
- R9: AND (op 11), OR (op 12), EOR (op 13) and BIT (op 14) combine reg with mem, clear V, update N and Z, keep C; BIT does not write.
- R10: CLR (op 10) returns zero with N = 0, Z = 1, V = 0, C = 0 regardless of inputs.
- R11: TST (op 9, no write) and LD (op 20, result = mem) and ST (op 21, result = reg) update N and Z from that value, clear V, keep C.
- R12: SEX (op 22) returns all bits equal to bit 7 of reg (the high half of the 16-bit extension), sets N to reg bit 7 and Z when reg is zero, keeps V and C.
- R13: H changes only on ADD and ADC. Op codes 23 to 31 give `result_we` = 0 and leave `cc_q` unchanged; `result_we` is 0 whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select |
| reg_opnd | input | 8 | Register operand (left side) |
| mem_opnd | input | 8 | Memory operand (right side, or sole operand) |
| cc_in | input | 8 | Current condition-code byte |
| result | output | 8 | Combinational data result |
| result_we | output | 1 | Result is to be written back |
| cc_q | output | 8 | Registered condition-code byte |

## Verification
The hardest cases are those where the flag rules of neighbouring operations diverge on the same operand: overflow at the 8'h7F/8'h80 boundary for increment, decrement, negate and left shifts, and carry-in or borrow-in entering through bit 0 of `cc_in` for the with-carry forms and rotates. The stimulus table pairs each such boundary operand with a chosen incoming condition byte, so that both the flags an operation must change and the ones it must keep are visible in `cc_q` after one edge. Directed steps then cover reset, idle cycles and unused op codes.

// File: rtl/cc_alu8_pkg.sv
package cc_alu8_pkg;

  localparam int DW  = 8;
  localparam int OPW = 5;
  localparam int NFL = 5;

  // condition-code bit positions
  localparam int CC_E = 7;
  localparam int CC_F = 6;
  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  // index inside the packed flag vectors {h,n,z,v,c}
  localparam int FH = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  localparam logic [NFL-1:0] UPD_HNZVC = 5'b11111;
  localparam logic [NFL-1:0] UPD_NZVC  = 5'b01111;
  localparam logic [NFL-1:0] UPD_NZV   = 5'b01110;
  localparam logic [NFL-1:0] UPD_NZC   = 5'b01101;
  localparam logic [NFL-1:0] UPD_NZ    = 5'b01100;

  typedef enum logic [OPW-1:0] {
    OP_NEG = 5'd0,  OP_COM = 5'd1,  OP_LSR = 5'd2,  OP_ASR = 5'd3,
    OP_ASL = 5'd4,  OP_ROL = 5'd5,  OP_ROR = 5'd6,  OP_INC = 5'd7,
    OP_DEC = 5'd8,  OP_TST = 5'd9,  OP_CLR = 5'd10, OP_AND = 5'd11,
    OP_OR  = 5'd12, OP_EOR = 5'd13, OP_BIT = 5'd14, OP_ADD = 5'd15,
    OP_ADC = 5'd16, OP_SUB = 5'd17, OP_SBC = 5'd18, OP_CMP = 5'd19,
    OP_LD  = 5'd20, OP_ST  = 5'd21, OP_SEX = 5'd22
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0]  res;
    logic           we;
    logic [NFL-1:0] upd;
    logic [NFL-1:0] flg;
  } unit_out_t;

  typedef struct packed {
    logic          h;
    logic          v;
    logic          c;
    logic [DW-1:0] res;
  } core_t;

  function automatic core_t add_core(input logic [DW-1:0] a,
                                     input logic [DW-1:0] b,
                                     input logic cin);
    core_t o;
    logic [DW:0] full;
    logic [4:0]  half;
    full  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    half  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
    o.res = full[DW-1:0];
    o.c   = full[DW];
    o.h   = half[4];
    o.v   = (a[DW-1] == b[DW-1]) && (o.res[DW-1] != a[DW-1]);
    return o;
  endfunction

  function automatic core_t sub_core(input logic [DW-1:0] a,
                                     input logic [DW-1:0] b,
                                     input logic bin);
    core_t o;
    logic [DW:0] full;
    full  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    o.res = full[DW-1:0];
    o.c   = full[DW];
    o.h   = 1'b0;
    o.v   = (a[DW-1] != b[DW-1]) && (o.res[DW-1] != a[DW-1]);
    return o;
  endfunction

  function automatic int flag_pos(input int idx);
    case (idx)
      FH:      return CC_H;
      FN:      return CC_N;
      FZ:      return CC_Z;
      FV:      return CC_V;
      default: return CC_C;
    endcase
  endfunction

endpackage

// File: rtl/cc_alu8_arith.sv
module cc_alu8_arith
  import cc_alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a_opnd,
  input  logic [DW-1:0]  b_opnd,
  input  logic           c_in,
  output logic           hit,
  output unit_out_t      o
);

  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ZERO = '0;

  core_t k;

  always_comb begin
    hit   = 1'b1;
    k     = '0;
    o     = '0;
    o.we  = 1'b1;
    case (op)
      OP_ADD: begin k = add_core(a_opnd, b_opnd, 1'b0); o.upd = UPD_HNZVC; end
      OP_ADC: begin k = add_core(a_opnd, b_opnd, c_in); o.upd = UPD_HNZVC; end
      OP_SUB: begin k = sub_core(a_opnd, b_opnd, 1'b0); o.upd = UPD_NZVC; end
      OP_SBC: begin k = sub_core(a_opnd, b_opnd, c_in); o.upd = UPD_NZVC; end
      OP_CMP: begin
        k     = sub_core(a_opnd, b_opnd, 1'b0);
        o.upd = UPD_NZVC;
        o.we  = 1'b0;
      end
      OP_NEG: begin k = sub_core(ZERO, b_opnd, 1'b0); o.upd = UPD_NZVC; end
      OP_INC: begin k = add_core(b_opnd, ONE, 1'b0);  o.upd = UPD_NZV; end
      OP_DEC: begin k = sub_core(b_opnd, ONE, 1'b0);  o.upd = UPD_NZV; end
      default: begin
        hit  = 1'b0;
        o.we = 1'b0;
      end
    endcase
    if (hit) begin
      o.res     = k.res;
      o.flg[FH] = k.h;
      o.flg[FN] = k.res[DW-1];
      o.flg[FZ] = (k.res == '0);
      o.flg[FV] = k.v;
      o.flg[FC] = k.c;
    end
  end

  // R3: compare never requests a write-back
  always_comb begin
    if (!$isunknown(op) && op == OP_CMP)
      a_r3_cmp_no_write: assert (!o.we);
  end

endmodule

// File: rtl/cc_alu8_shift.sv
module cc_alu8_shift
  import cc_alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  b_opnd,
  input  logic           c_in,
  output logic           hit,
  output unit_out_t      o
);

  logic [DW-1:0] sh_res;
  logic          fill_hi;
  logic          fill_lo;
  logic          go_left;
  logic          c_out;

  // fill bits and direction chosen per operation
  always_comb begin
    hit     = 1'b1;
    go_left = 1'b0;
    fill_hi = 1'b0;
    fill_lo = 1'b0;
    case (op)
      OP_LSR: fill_hi = 1'b0;
      OP_ASR: fill_hi = b_opnd[DW-1];
      OP_ROR: fill_hi = c_in;
      OP_ASL: begin go_left = 1'b1; fill_lo = 1'b0; end
      OP_ROL: begin go_left = 1'b1; fill_lo = c_in; end
      default: hit = 1'b0;
    endcase
  end

  // bit-level shifter: each bit takes its neighbour in the chosen direction
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic from_right;
    logic from_left;
    if (i == 0) begin : g_lo
      assign from_right = fill_lo;
    end else begin : g_mid_r
      assign from_right = b_opnd[i-1];
    end
    if (i == DW - 1) begin : g_hi
      assign from_left = fill_hi;
    end else begin : g_mid_l
      assign from_left = b_opnd[i+1];
    end
    assign sh_res[i] = go_left ? from_right : from_left;
  end

  assign c_out = go_left ? b_opnd[DW-1] : b_opnd[0];

  always_comb begin
    o = '0;
    if (hit) begin
      o.res     = sh_res;
      o.we      = 1'b1;
      o.upd     = go_left ? UPD_NZVC : UPD_NZC;
      o.flg[FN] = sh_res[DW-1];
      o.flg[FZ] = (sh_res == '0);
      o.flg[FV] = b_opnd[DW-1] ^ b_opnd[DW-2];
      o.flg[FC] = c_out;
    end
  end

  // R7: logical right shift always leaves the top bit clear
  always_comb begin
    if (!$isunknown(op) && op == OP_LSR)
      a_r7_lsr_top_clear: assert (!o.res[DW-1]);
  end

endmodule

// File: rtl/cc_alu8_logic.sv
module cc_alu8_logic
  import cc_alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a_opnd,
  input  logic [DW-1:0]  b_opnd,
  output logic           hit,
  output unit_out_t      o
);

  logic [DW-1:0] val;
  logic          ext_zero;

  always_comb begin
    hit      = 1'b1;
    val      = '0;
    ext_zero = 1'b0;
    o        = '0;
    o.we     = 1'b1;
    o.upd    = UPD_NZV;
    case (op)
      OP_AND: val = a_opnd & b_opnd;
      OP_OR:  val = a_opnd | b_opnd;
      OP_EOR: val = a_opnd ^ b_opnd;
      OP_BIT: begin val = a_opnd & b_opnd; o.we = 1'b0; end
      OP_TST: begin val = b_opnd;          o.we = 1'b0; end
      OP_LD:  val = b_opnd;
      OP_ST:  val = a_opnd;
      OP_COM: begin
        val       = ~b_opnd;
        o.upd     = UPD_NZVC;
        o.flg[FC] = 1'b1;
      end
      OP_CLR: begin
        val   = '0;
        o.upd = UPD_NZVC;
      end
      OP_SEX: begin
        val      = {DW{a_opnd[DW-1]}};
        o.upd    = UPD_NZ;
        ext_zero = (a_opnd == '0);
      end
      default: begin
        hit   = 1'b0;
        o.we  = 1'b0;
        o.upd = '0;
      end
    endcase
    if (hit) begin
      o.res     = val;
      o.flg[FN] = val[DW-1];
      o.flg[FZ] = (op == OP_SEX) ? ext_zero : (val == '0);
      o.flg[FV] = 1'b0;
    end
  end

  // R9: bitwise operations request a V update and supply zero
  always_comb begin
    if (!$isunknown(op) && (op == OP_AND || op == OP_OR ||
                            op == OP_EOR || op == OP_BIT))
      a_r9_v_cleared: assert (o.upd[FV] && !o.flg[FV] && !o.upd[FH]);
  end

endmodule

// File: rtl/cc_alu8.sv
module cc_alu8
  import cc_alu8_pkg::*;
#(
  parameter logic [DW-1:0] CC_RESET = 8'h50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  reg_opnd,
  input  logic [DW-1:0]  mem_opnd,
  input  logic [DW-1:0]  cc_in,
  output logic [DW-1:0]  result,
  output logic           result_we,
  output logic [DW-1:0]  cc_q
);

  logic      ar_hit, sh_hit, lg_hit;
  unit_out_t ar_o, sh_o, lg_o, all_o;
  logic      op_known;
  logic      cc_load;
  logic [DW-1:0] cc_merge;

  cc_alu8_arith u_arith (
    .op     (op_code),
    .a_opnd (reg_opnd),
    .b_opnd (mem_opnd),
    .c_in   (cc_in[CC_C]),
    .hit    (ar_hit),
    .o      (ar_o)
  );

  cc_alu8_shift u_shift (
    .op     (op_code),
    .b_opnd (mem_opnd),
    .c_in   (cc_in[CC_C]),
    .hit    (sh_hit),
    .o      (sh_o)
  );

  cc_alu8_logic u_logic (
    .op     (op_code),
    .a_opnd (reg_opnd),
    .b_opnd (mem_opnd),
    .hit    (lg_hit),
    .o      (lg_o)
  );

  // units drive zero when idle, so the union is a plain OR
  assign all_o    = unit_out_t'(ar_o | sh_o | lg_o);
  assign op_known = ar_hit | sh_hit | lg_hit;
  assign cc_load  = op_valid & op_known;

  assign result    = all_o.res;
  assign result_we = op_valid & all_o.we;

  // untouched state and mask bits
  assign cc_merge[CC_E] = cc_in[CC_E];
  assign cc_merge[CC_F] = cc_in[CC_F];
  assign cc_merge[CC_I] = cc_in[CC_I];

  for (genvar f = 0; f < NFL; f++) begin : g_flag
    localparam int P = flag_pos(f);
    assign cc_merge[P] = all_o.upd[f] ? all_o.flg[f] : cc_in[P];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cc_q <= CC_RESET;
    else if (cc_load)
      cc_q <= cc_merge;
  end

  // R13: the three units decode disjoint op codes
  a_r13_unit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_hit, sh_hit, lg_hit}));

  // R1: idle or unknown ops leave the register alone
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_load |=> $stable(cc_q));

  // R1: state and mask bits follow the incoming byte
  a_r1_state_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load |=> (cc_q[CC_E] == $past(cc_in[CC_E])) &&
                (cc_q[CC_F] == $past(cc_in[CC_F])) &&
                (cc_q[CC_I] == $past(cc_in[CC_I])));

  // R5: increment and decrement keep carry
  a_r5_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load && (op_code == OP_INC || op_code == OP_DEC)
      |=> cc_q[CC_C] == $past(cc_in[CC_C]));

  // R6: complement forces carry high and overflow low
  a_r6_com_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load && op_code == OP_COM |=> cc_q[CC_C] && !cc_q[CC_V]);

  // R10: clear always leaves only Z among N,Z,V,C
  a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load && op_code == OP_CLR |=> cc_q[3:0] == 4'b0100);

  // R13: half-carry changes only on the add forms
  a_r13_h_only_add: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load && op_code != OP_ADD && op_code != OP_ADC
      |=> cc_q[CC_H] == $past(cc_in[CC_H]));

  // R13: no write request without a valid operation
  a_r13_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);

endmodule

// File: tb/cc_alu8_bench.sv
module cc_alu8_bench;

  localparam int K_NEG = 0,  K_COM = 1,  K_LSR = 2,  K_ASR = 3;
  localparam int K_ASL = 4,  K_ROL = 5,  K_ROR = 6,  K_INC = 7;
  localparam int K_DEC = 8,  K_TST = 9,  K_CLR = 10, K_AND = 11;
  localparam int K_OR  = 12, K_EOR = 13, K_BIT = 14, K_ADD = 15;
  localparam int K_ADC = 16, K_SUB = 17, K_SBC = 18, K_CMP = 19;
  localparam int K_LD  = 20, K_ST  = 21, K_SEX = 22;

  localparam int NV = 40;
  // {op, reg, mem, cc}
  localparam logic [28:0] VEC [NV] = '{
    {5'd0,  8'h00, 8'h00, 8'h00}, {5'd0,  8'h00, 8'h80, 8'h00},
    {5'd0,  8'h00, 8'h01, 8'hF0}, {5'd1,  8'h00, 8'h55, 8'h02},
    {5'd2,  8'h00, 8'h81, 8'h00}, {5'd3,  8'h00, 8'h81, 8'h00},
    {5'd3,  8'h00, 8'h02, 8'h01}, {5'd4,  8'h00, 8'hC0, 8'h00},
    {5'd4,  8'h00, 8'h40, 8'h00}, {5'd5,  8'h00, 8'h80, 8'h01},
    {5'd5,  8'h00, 8'h41, 8'h00}, {5'd6,  8'h00, 8'h01, 8'h00},
    {5'd6,  8'h00, 8'h00, 8'h01}, {5'd7,  8'h00, 8'h7F, 8'h01},
    {5'd7,  8'h00, 8'hFF, 8'h00}, {5'd8,  8'h00, 8'h80, 8'h00},
    {5'd8,  8'h00, 8'h01, 8'h01}, {5'd9,  8'h00, 8'h00, 8'h03},
    {5'd9,  8'h00, 8'h90, 8'h02}, {5'd10, 8'h00, 8'h12, 8'hFF},
    {5'd11, 8'hF0, 8'h0F, 8'h02}, {5'd12, 8'h80, 8'h01, 8'h00},
    {5'd13, 8'hFF, 8'hFF, 8'h02}, {5'd14, 8'hC0, 8'h80, 8'h01},
    {5'd15, 8'h7F, 8'h01, 8'h00}, {5'd15, 8'hFF, 8'h01, 8'h00},
    {5'd16, 8'h08, 8'h08, 8'h01}, {5'd16, 8'h7F, 8'h00, 8'h01},
    {5'd17, 8'h00, 8'h01, 8'h00}, {5'd17, 8'h80, 8'h01, 8'h00},
    {5'd18, 8'h05, 8'h05, 8'h01}, {5'd18, 8'h10, 8'h0F, 8'h01},
    {5'd19, 8'h42, 8'h42, 8'h00}, {5'd19, 8'h01, 8'h02, 8'h00},
    {5'd20, 8'h00, 8'h00, 8'h0B}, {5'd20, 8'h00, 8'hF0, 8'h00},
    {5'd21, 8'h7E, 8'h00, 8'h02}, {5'd22, 8'h80, 8'h00, 8'h02},
    {5'd22, 8'h00, 8'h00, 8'h0F}, {5'd22, 8'h05, 8'h00, 8'h04}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] reg_opnd = '0;
  logic [7:0] mem_opnd = '0;
  logic [7:0] cc_in = '0;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] cc_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  cc_alu8 u_cc_alu8 (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .reg_opnd (reg_opnd), .mem_opnd (mem_opnd), .cc_in (cc_in),
    .result (result), .result_we (result_we), .cc_q (cc_q)
  );

  function automatic string rtag(input int op);
    case (op)
      K_ADD, K_ADC:               return "R2";
      K_SUB, K_SBC, K_CMP:        return "R3";
      K_NEG:                      return "R4";
      K_INC, K_DEC:               return "R5";
      K_COM:                      return "R6";
      K_LSR, K_ASR:               return "R7";
      K_ASL, K_ROL, K_ROR:        return "R8";
      K_AND, K_OR, K_EOR, K_BIT:  return "R9";
      K_CLR:                      return "R10";
      K_TST, K_LD, K_ST:          return "R11";
      K_SEX:                      return "R12";
      default:                    return "R13";
    endcase
  endfunction

  function automatic int put(input int x, input int pos, input int b);
    return b ? (x | (1 << pos)) : (x & ~(1 << pos));
  endfunction

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // reference written with integer arithmetic: {we, result, cc}
  function automatic logic [16:0] model(input int op, input int r,
                                        input int m, input int cc);
    int res, we, t, ci, s;
    int nc;
    bit dn;
    we = 1; res = 0; nc = cc; dn = 1'b1;
    ci = cc & 1;
    case (op)
      K_NEG: begin res = (256 - m) % 256; nc = put(nc, 0, m != 0);
                   nc = put(nc, 1, m == 128); end
      K_COM: begin res = 255 - m; nc = put(nc, 0, 1); nc = put(nc, 1, 0); end
      K_LSR: begin res = m / 2; nc = put(nc, 0, m % 2); end
      K_ASR: begin res = m / 2 + ((m >= 128) ? 128 : 0); nc = put(nc, 0, m % 2); end
      K_ASL, K_ROL: begin
        res = (m * 2) % 256 + ((op == K_ROL) ? ci : 0);
        nc = put(nc, 0, m >= 128);
        nc = put(nc, 1, (m >= 128) != ((m % 128) >= 64));
      end
      K_ROR: begin res = m / 2 + ci * 128; nc = put(nc, 0, m % 2); end
      K_INC: begin res = (m + 1) % 256; nc = put(nc, 1, sgn(m) + 1 > 127); end
      K_DEC: begin res = (m + 255) % 256; nc = put(nc, 1, sgn(m) - 1 < -128); end
      K_TST: begin res = m; we = 0; nc = put(nc, 1, 0); end
      K_CLR: begin res = 0; nc = put(nc, 1, 0); nc = put(nc, 0, 0); end
      K_AND: begin res = r & m; nc = put(nc, 1, 0); end
      K_OR:  begin res = r | m; nc = put(nc, 1, 0); end
      K_EOR: begin res = r ^ m; nc = put(nc, 1, 0); end
      K_BIT: begin res = r & m; we = 0; nc = put(nc, 1, 0); end
      K_ADD, K_ADC: begin
        t = (op == K_ADC) ? ci : 0;
        s = r + m + t; res = s % 256;
        nc = put(nc, 0, s > 255);
        nc = put(nc, 5, (r % 16 + m % 16 + t) > 15);
        s = sgn(r) + sgn(m) + t;
        nc = put(nc, 1, s > 127 || s < -128);
      end
      K_SUB, K_SBC, K_CMP: begin
        t = (op == K_SBC) ? ci : 0;
        s = r - m - t; res = (s + 256) % 256;
        nc = put(nc, 0, s < 0);
        s = sgn(r) - sgn(m) - t;
        nc = put(nc, 1, s > 127 || s < -128);
        if (op == K_CMP) we = 0;
      end
      K_LD: begin res = m; nc = put(nc, 1, 0); end
      K_ST: begin res = r; nc = put(nc, 1, 0); end
      K_SEX: begin
        res = (r >= 128) ? 255 : 0;
        nc = put(nc, 3, r >= 128); nc = put(nc, 2, r == 0);
        dn = 1'b0;
      end
      default: begin we = 0; dn = 1'b0; end
    endcase
    if (dn) begin
      nc = put(nc, 3, res >= 128);
      nc = put(nc, 2, res == 0);
    end
    return {we[0], res[7:0], nc[7:0]};
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, sample comb half a phase later, sample register
  // one time unit after the rising edge
  task automatic run_op(input int op, input int r, input int m, input int cc,
                        input bit valid, output int c_res, output int c_we,
                        output int c_cc);
    @(negedge clk);
    op_valid = valid;
    op_code  = op[4:0];
    reg_opnd = r[7:0];
    mem_opnd = m[7:0];
    cc_in    = cc[7:0];
    #1;
    c_res = int'(result);
    c_we  = int'(result_we);
    @(posedge clk);
    #1;
    c_cc = int'(cc_q);
    op_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int a_res, a_we, a_cc, prev;
    logic [16:0] e;

    // reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset cc_q", int'(cc_q), 'h50);
    check("R13", "reset result_we", int'(result_we), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      int op, r, m, cc;
      op = int'(VEC[i][28:24]);
      r  = int'(VEC[i][23:16]);
      m  = int'(VEC[i][15:8]);
      cc = int'(VEC[i][7:0]);
      e  = model(op, r, m, cc);
      run_op(op, r, m, cc, 1'b1, a_res, a_we, a_cc);
      check(rtag(op), $sformatf("vec %0d we", i), a_we, int'(e[16]));
      if (e[16]) check(rtag(op), $sformatf("vec %0d result", i), a_res, int'(e[15:8]));
      check(rtag(op), $sformatf("vec %0d cc", i), a_cc, int'(e[7:0]));
    end

    // directed hand-computed corners
    run_op(K_ADD, 'h7F, 'h01, 'h00, 1'b1, a_res, a_we, a_cc);
    check("R2", "add 7F+01 result", a_res, 'h80);
    check("R2", "add 7F+01 cc", a_cc, 'h2A);
    run_op(K_SUB, 'h00, 'h01, 'h00, 1'b1, a_res, a_we, a_cc);
    check("R3", "sub 00-01 result", a_res, 'hFF);
    check("R3", "sub 00-01 cc", a_cc, 'h09);
    run_op(K_CLR, 'hAA, 'h55, 'hFF, 1'b1, a_res, a_we, a_cc);
    check("R10", "clr result", a_res, 'h00);
    check("R10", "clr cc", a_cc, 'hF4);
    run_op(K_COM, 'h00, 'h00, 'h00, 1'b1, a_res, a_we, a_cc);
    check("R6", "com 00 cc", a_cc, 'h09);
    run_op(K_SEX, 'h80, 'h00, 'h00, 1'b1, a_res, a_we, a_cc);
    check("R12", "sex 80 result", a_res, 'hFF);
    check("R12", "sex 80 cc", a_cc, 'h08);
    run_op(K_ROL, 'h00, 'h80, 'h01, 1'b1, a_res, a_we, a_cc);
    check("R8", "rol 80 c=1 result", a_res, 'h01);
    check("R8", "rol 80 c=1 cc", a_cc, 'h03);

    // idle cycle holds register, no write (R1, R13)
    prev = int'(cc_q);
    run_op(K_ADD, 'hFF, 'hFF, 'hF5, 1'b0, a_res, a_we, a_cc);
    check("R1", "idle keeps cc_q", a_cc, prev);
    check("R13", "idle result_we", a_we, 0);

    // unused op codes ignored (R13)
    for (int u = 23; u < 32; u++) begin
      prev = int'(cc_q);
      run_op(u, 'h12, 'h34, 'hFF, 1'b1, a_res, a_we, a_cc);
      check("R13", $sformatf("op %0d result_we", u), a_we, 0);
      check("R13", $sformatf("op %0d keeps cc_q", u), a_cc, prev);
    end

    // state bits pass on a loaded op (R1)
    run_op(K_LD, 'h00, 'h01, 'hD0, 1'b1, a_res, a_we, a_cc);
    check("R1", "state bits carried", a_cc & 'hD0, 'hD0);
    check("R11", "ld 01 cc", a_cc, 'hD0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule